// File: doc/BRIEF.md
# FIFO Flag Interrupt Controller

This block watches the status flags of four endpoint FIFOs and turns flag transitions into latched interrupt requests. Every FIFO presents three flags: a programmable-level flag, an empty flag and a full flag. Each endpoint has an enable register that selects which flags may interrupt, and for the programmable flag, which transition counts. Requests are held in per-endpoint request registers that software clears by writing ones. All enabled, pending requests are merged onto one interrupt line, which a two-bit global setup register gates.

A byte-wide register port gives software read and write access to the enable, request and setup registers. A source code output names the most urgent pending, enabled source, so a handler can dispatch without scanning the request registers. The flag inputs pass through one register stage before transitions are detected.

Top module: `fifo_flag_irq`

## Requirements
- R1: Endpoint e (e = 0..3) has an enable register at 0xE650 + 2e. Its bit 3 picks the programmable-flag edge, bit 2 enables the programmable flag, bit 1 the empty flag and bit 0 the full flag. Bits 7..4 read 0, and all bits reset to 0.
- R2: Endpoint e has a request register at 0xE651 + 2e. Bit 2 is the programmable flag, bit 1 the empty flag and bit 0 the full flag. Bits 7..3 read 0, and all bits reset to 0.
- R3: The setup register is at 0xE668. Bit 1 is source select and bit 0 is vector enable. Bits 7..2 read 0, and both bits reset to 0.
- R4: A rising edge on an empty or full flag sets its request bit whether or not the bit is enabled. A flag change present at clock edge k appears in the request register after clock edge k+1.
- R5: With edge-select 0, the programmable flag sets its request on a rising edge. With edge-select 1, it sets its request on a falling edge only.
- R6: Writing 1 to a request bit clears it, and writing 0 leaves it unchanged. If a clearing write and a detected edge hit the same bit in the same cycle, the bit ends up set.
- R7: `irq_out` is 1 exactly when some request bit is 1 with its enable bit also 1, and both setup bits are 1. It follows register contents without further delay.
- R8: `irq_src` equals 3*e + k for the pending, enabled source with the lowest e. Within an endpoint, k = 0 is the programmable flag, k = 1 the empty flag and k = 2 the full flag, and the lower k wins. When nothing is pending and enabled, `irq_src` is 0xF. The setup bits have no effect on `irq_src`.
- R9: Flag levels already present when reset is released set no request.
- R10: Any address outside the nine mapped registers reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_prog | input | 4 | Programmable-level flag per endpoint |
| flag_empty | input | 4 | Empty flag per endpoint |
| flag_full | input | 4 | Full flag per endpoint |
| bus_addr | input | 16 | Register address, used for both read and write |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Shared interrupt line |
| irq_src | output | 4 | Code of the most urgent pending, enabled source |

## Verification
Directed sequences first drive each flag kind through both of its transitions in turn. This separates the two edge-select settings and shows that empty and full flags ignore falling edges. A clearing write is placed in the same cycle as a detected edge to show that the set wins. Setup values 01, 10 and 11 show that only the pair gates the line, while the source code stays visible. The random phase then toggles sparse flag bits and mixes writes to every mapped and some unmapped addresses. Each cycle compares the line, the source code and the read data against a model, which exposes priority ordering among simultaneous requests.

// File: rtl/ffirq_pkg.sv
`timescale 1ns/1ps
package ffirq_pkg;

   // bit positions shared by flag vectors, request registers and enable registers
   localparam int FLG_FULL  = 0;
   localparam int FLG_EMPTY = 1;
   localparam int FLG_PROG  = 2;
   localparam int FLG_NUM   = 3;

   typedef struct packed {
      logic fall_sel;
      logic prog_en;
      logic empty_en;
      logic full_en;
   } ep_en_t;

   typedef struct packed {
      logic src_sel;
      logic vec_en;
   } setup_t;

   function automatic logic [FLG_NUM-1:0] en_mask(input ep_en_t e);
      return {e.prog_en, e.empty_en, e.full_en};
   endfunction

endpackage

// File: rtl/ffirq_flag_sync.sv
`timescale 1ns/1ps
module ffirq_flag_sync #(
   parameter int WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] flags_in,
   output logic [WIDTH-1:0] cur_q,
   output logic [WIDTH-1:0] prv_q
);

   logic primed_q;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ffirq_flag_sync: WIDTH must be at least 1");
      end
   endgenerate

   // first clock after reset loads both stages so a level present at reset is no edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q    <= '0;
         prv_q    <= '0;
         primed_q <= 1'b0;
      end else begin
         cur_q    <= flags_in;
         prv_q    <= primed_q ? cur_q : flags_in;
         primed_q <= 1'b1;
      end
   end

endmodule

// File: rtl/ffirq_ep_slice.sv
`timescale 1ns/1ps
module ffirq_ep_slice
   import ffirq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FLG_NUM-1:0] cur,
   input  logic [FLG_NUM-1:0] prv,
   input  logic               en_we,
   input  logic               req_we,
   input  logic [3:0]         wdata,
   output ep_en_t             en_q,
   output logic [FLG_NUM-1:0] req_q,
   output logic [FLG_NUM-1:0] set_o
);

   logic [FLG_NUM-1:0] rise, fall, clr, req_d;

   assign rise = cur & ~prv;
   assign fall = ~cur & prv;

   always_comb begin
      set_o            = '0;
      set_o[FLG_FULL]  = rise[FLG_FULL];
      set_o[FLG_EMPTY] = rise[FLG_EMPTY];
      set_o[FLG_PROG]  = en_q.fall_sel ? fall[FLG_PROG] : rise[FLG_PROG];
   end

   assign clr   = req_we ? wdata[FLG_NUM-1:0] : '0;
   assign req_d = (req_q & ~clr) | set_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         req_q <= '0;
      end else begin
         req_q <= req_d;
         if (en_we) en_q <= ep_en_t'(wdata);
      end
   end

endmodule

// File: rtl/ffirq_prio.sv
`timescale 1ns/1ps
module ffirq_prio
   import ffirq_pkg::*;
#(
   parameter int NUM_EP = 4,
   parameter int CODE_W = 4
) (
   input  logic [FLG_NUM*NUM_EP-1:0] pend,
   output logic [CODE_W-1:0]         code
);

   localparam logic [CODE_W-1:0] CODE_NONE = '1;

   generate
      if ((1 << CODE_W) <= FLG_NUM*NUM_EP) begin : g_bad_code
         $error("ffirq_prio: CODE_W too narrow for all sources plus the idle code");
      end
   endgenerate

   // scan from least to most urgent; the last hit is the most urgent
   always_comb begin
      code = CODE_NONE;
      for (int e = NUM_EP-1; e >= 0; e--) begin
         for (int k = 0; k < FLG_NUM; k++) begin
            if (pend[e*FLG_NUM + k]) code = CODE_W'(e*FLG_NUM + (FLG_NUM-1-k));
         end
      end
   end

endmodule

// File: rtl/fifo_flag_irq.sv
`timescale 1ns/1ps
module fifo_flag_irq
   import ffirq_pkg::*;
#(
   parameter int                NUM_EP     = 4,
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'hE650,
   parameter logic [ADDR_W-1:0] SETUP_ADDR = 16'hE668,
   parameter int                CODE_W     = $clog2(3*NUM_EP+1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EP-1:0] flag_prog,
   input  logic [NUM_EP-1:0] flag_empty,
   input  logic [NUM_EP-1:0] flag_full,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq_out,
   output logic [CODE_W-1:0] irq_src
);

   localparam int NSRC = FLG_NUM*NUM_EP;

   generate
      if (NUM_EP < 1) begin : g_bad_ep
         $error("fifo_flag_irq: NUM_EP must be at least 1");
      end
      if (BASE_ADDR[0] != 1'b0) begin : g_bad_base
         $error("fifo_flag_irq: BASE_ADDR must be even");
      end
      if (SETUP_ADDR >= BASE_ADDR && SETUP_ADDR < BASE_ADDR + ADDR_W'(2*NUM_EP)) begin : g_bad_setup
         $error("fifo_flag_irq: SETUP_ADDR overlaps the endpoint registers");
      end
   endgenerate

   logic [NSRC-1:0]   flag_flat, cur_flat, prv_flat;
   logic [NSRC-1:0]   req_all, set_all, pend_all;
   logic [NUM_EP-1:0] en_we, req_we;
   ep_en_t            en_arr [NUM_EP];
   setup_t            setup_q;
   logic              unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata[7:4];

   ffirq_flag_sync #(.WIDTH(NSRC)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .flags_in (flag_flat),
      .cur_q    (cur_flat),
      .prv_q    (prv_flat)
   );

   generate
      for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
         assign flag_flat[e*FLG_NUM +: FLG_NUM] = {flag_prog[e], flag_empty[e], flag_full[e]};
         assign en_we[e]  = bus_we && (bus_addr == BASE_ADDR + ADDR_W'(2*e));
         assign req_we[e] = bus_we && (bus_addr == BASE_ADDR + ADDR_W'(2*e+1));

         ffirq_ep_slice u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .cur    (cur_flat[e*FLG_NUM +: FLG_NUM]),
            .prv    (prv_flat[e*FLG_NUM +: FLG_NUM]),
            .en_we  (en_we[e]),
            .req_we (req_we[e]),
            .wdata  (bus_wdata[3:0]),
            .en_q   (en_arr[e]),
            .req_q  (req_all[e*FLG_NUM +: FLG_NUM]),
            .set_o  (set_all[e*FLG_NUM +: FLG_NUM])
         );

         assign pend_all[e*FLG_NUM +: FLG_NUM] = req_all[e*FLG_NUM +: FLG_NUM] & en_mask(en_arr[e]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) setup_q <= '0;
      else if (bus_we && bus_addr == SETUP_ADDR) setup_q <= setup_t'(bus_wdata[1:0]);
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == SETUP_ADDR) bus_rdata = {6'b0, setup_q};
      for (int e = 0; e < NUM_EP; e++) begin
         if (bus_addr == BASE_ADDR + ADDR_W'(2*e))   bus_rdata = {4'b0, en_arr[e]};
         if (bus_addr == BASE_ADDR + ADDR_W'(2*e+1)) bus_rdata = {5'b0, req_all[e*FLG_NUM +: FLG_NUM]};
      end
   end

   assign irq_out = (|pend_all) && setup_q.src_sel && setup_q.vec_en;

   ffirq_prio #(.NUM_EP(NUM_EP), .CODE_W(CODE_W)) u_prio (
      .pend (pend_all),
      .code (irq_src)
   );

endmodule

// File: rtl/ffirq_checker.sv
`timescale 1ns/1ps
module ffirq_checker #(
   parameter int                NUM_EP    = 4,
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hE650,
   parameter int                CODE_W    = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [7:0]          bus_rdata,
   input logic                irq_out,
   input logic [CODE_W-1:0]   irq_src,
   input logic [1:0]          setup_q,
   input logic [3*NUM_EP-1:0] req_all,
   input logic [3*NUM_EP-1:0] set_all
);

   logic [1:0] cyc;
   logic       at_en, at_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= '0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   always_comb begin
      at_en  = 1'b0;
      at_req = 1'b0;
      for (int e = 0; e < NUM_EP; e++) begin
         if (bus_addr == BASE_ADDR + ADDR_W'(2*e))   at_en  = 1'b1;
         if (bus_addr == BASE_ADDR + ADDR_W'(2*e+1)) at_req = 1'b1;
      end
   end

   assert_en_high_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      at_en |-> bus_rdata[7:4] == 4'b0);

   assert_req_high_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      at_req |-> bus_rdata[7:3] == 5'b0);

   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_all) |=> ((req_all & $past(set_all)) == $past(set_all)));

   assert_line_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> setup_q == 2'b11);

   assert_src_matches_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> irq_src != '1);

   assert_quiet_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd2) |-> req_all == '0);

endmodule

bind fifo_flag_irq ffirq_checker #(
   .NUM_EP    (NUM_EP),
   .ADDR_W    (ADDR_W),
   .BASE_ADDR (BASE_ADDR),
   .CODE_W    (CODE_W)
) u_ffirq_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .irq_out   (irq_out),
   .irq_src   (irq_src),
   .setup_q   (setup_q),
   .req_all   (req_all),
   .set_all   (set_all)
);

// File: tb/fifo_flag_irq_bench.sv
`timescale 1ns/1ps
module fifo_flag_irq_bench;

   localparam logic [15:0] BASE  = 16'hE650;
   localparam logic [15:0] SETUP = 16'hE668;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  flag_prog = '1, flag_empty = '1, flag_full = '1;
   logic [15:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        irq_out;
   logic [3:0]  irq_src;

   int n_checks = 0;
   int n_err = 0;

   // model state
   logic [3:0] m_en  [4];
   logic [2:0] m_req [4];
   logic [2:0] m_cur [4];
   logic [2:0] m_prv [4];
   logic [1:0] m_setup;
   logic       m_primed;

   fifo_flag_irq u_fifo_flag_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .flag_prog  (flag_prog),
      .flag_empty (flag_empty),
      .flag_full  (flag_full),
      .bus_addr   (bus_addr),
      .bus_we     (bus_we),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .irq_out    (irq_out),
      .irq_src    (irq_src)
   );

   always #2.5 clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic m_reset();
      for (int e = 0; e < 4; e++) begin
         m_en[e] = '0; m_req[e] = '0; m_cur[e] = '0; m_prv[e] = '0;
      end
      m_setup  = '0;
      m_primed = 1'b0;
   endtask

   task automatic m_clock();
      for (int e = 0; e < 4; e++) begin
         logic [2:0] rise, fall, setv, clr, nflg;
         rise = m_cur[e] & ~m_prv[e];
         fall = ~m_cur[e] & m_prv[e];
         setv = {m_en[e][3] ? fall[2] : rise[2], rise[1], rise[0]};
         clr  = (bus_we && bus_addr == BASE + 16'(2*e+1)) ? bus_wdata[2:0] : 3'b0;
         m_req[e] = (m_req[e] & ~clr) | setv;
         if (bus_we && bus_addr == BASE + 16'(2*e)) m_en[e] = bus_wdata[3:0];
         nflg = {flag_prog[e], flag_empty[e], flag_full[e]};
         m_prv[e] = m_primed ? m_cur[e] : nflg;
         m_cur[e] = nflg;
      end
      if (bus_we && bus_addr == SETUP) m_setup = bus_wdata[1:0];
      m_primed = 1'b1;
   endtask

   function automatic logic m_irq();
      logic any = 1'b0;
      for (int e = 0; e < 4; e++) any |= |(m_req[e] & m_en[e][2:0]);
      return any && m_setup == 2'b11;
   endfunction

   function automatic logic [3:0] m_src();
      for (int e = 0; e < 4; e++) begin
         logic [2:0] p;
         p = m_req[e] & m_en[e][2:0];
         if (p[2]) return 4'(3*e);
         if (p[1]) return 4'(3*e+1);
         if (p[0]) return 4'(3*e+2);
      end
      return 4'hF;
   endfunction

   function automatic logic [7:0] m_rd(input logic [15:0] a);
      if (a == SETUP) return {6'b0, m_setup};
      for (int e = 0; e < 4; e++) begin
         if (a == BASE + 16'(2*e))   return {4'b0, m_en[e]};
         if (a == BASE + 16'(2*e+1)) return {5'b0, m_req[e]};
      end
      return 8'h00;
   endfunction

   function automatic string rd_tag(input logic [15:0] a);
      if (a == SETUP) return "R3 setup read";
      if (a >= BASE && a < BASE + 16'd8) return a[0] ? "R2 request read" : "R1 enable read";
      return "R10 unmapped read";
   endfunction

   task automatic compare_all();
      check("R7 irq_out", {31'b0, irq_out}, {31'b0, m_irq()});
      check("R8 irq_src", {28'b0, irq_src}, {28'b0, m_src()});
      check(rd_tag(bus_addr), {24'b0, bus_rdata}, {24'b0, m_rd(bus_addr)});
   endtask

   // called at a falling edge with inputs set; returns at the next falling edge
   task automatic step();
      @(posedge clk);
      m_clock();
      @(negedge clk);
      compare_all();
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      step();
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a);
      bus_addr = a;
      #1;
      compare_all();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd24680));
      m_reset();
      repeat (3) @(negedge clk);
      // reset state of every register and outputs (R1, R2, R3)
      for (int a = 0; a < 8; a++) rd(BASE + 16'(a));
      rd(SETUP);
      check("R8 irq_src idle at reset", {28'b0, irq_src}, 32'hF);
      @(negedge clk);
      rst_n = 1'b1;

      // flags high through reset release: no request (R9)
      repeat (3) step();
      for (int e = 0; e < 4; e++) begin
         rd(BASE + 16'(2*e+1));
         check("R9 no request from reset level", {24'b0, bus_rdata}, 32'h0);
      end

      flag_prog = '0; flag_empty = '0; flag_full = '0;
      step(); step();
      wr(SETUP, 8'h03);
      wr(BASE, 8'h04);

      // rising programmable flag, latency (R4, R5)
      flag_prog[0] = 1'b1;
      step();
      check("R4 not yet latched", {31'b0, irq_out}, 32'h0);
      step();
      check("R5 rising edge fires", {31'b0, irq_out}, 32'h1);
      check("R8 source ep0 prog", {28'b0, irq_src}, 32'h0);

      // write-one-to-clear (R6)
      wr(BASE + 16'd1, 8'h00);
      check("R6 zero write keeps bit", {24'b0, bus_rdata}, 32'h4);
      wr(BASE + 16'd1, 8'h04);
      check("R6 one write clears", {24'b0, bus_rdata}, 32'h0);

      // falling-edge mode (R5)
      wr(BASE + 16'd2, 8'h0C);
      flag_prog[1] = 1'b1;
      step(); step();
      rd(BASE + 16'd3);
      check("R5 rise ignored in fall mode", {24'b0, bus_rdata}, 32'h0);
      flag_prog[1] = 1'b0;
      step(); step();
      rd(BASE + 16'd3);
      check("R5 fall edge latched", {24'b0, bus_rdata}, 32'h4);
      check("R8 source ep1 prog", {28'b0, irq_src}, 32'h3);
      wr(BASE + 16'd3, 8'h07);

      // set beats a same-cycle clear (R6)
      flag_prog[0] = 1'b0;
      step(); step();
      flag_prog[0] = 1'b1;
      step();
      wr(BASE + 16'd1, 8'h04);
      check("R6 set wins over clear", {24'b0, bus_rdata}, 32'h4);
      wr(BASE + 16'd1, 8'h04);
      check("R6 later clear", {24'b0, bus_rdata}, 32'h0);

      // priority and setup gating (R7, R8), empty flag falling has no effect (R4)
      wr(BASE + 16'd6, 8'h01);
      wr(BASE + 16'd4, 8'h02);
      flag_full[3] = 1'b1; flag_empty[2] = 1'b1;
      step(); step();
      check("R8 ep2 empty beats ep3 full", {28'b0, irq_src}, 32'h7);
      wr(SETUP, 8'h01);
      check("R7 gated by source select", {31'b0, irq_out}, 32'h0);
      check("R8 code ungated", {28'b0, irq_src}, 32'h7);
      wr(SETUP, 8'h02);
      check("R7 gated by vector enable", {31'b0, irq_out}, 32'h0);
      wr(SETUP, 8'hFF);
      check("R3 setup upper bits zero", {24'b0, bus_rdata}, 32'h3);
      check("R7 both bits pass", {31'b0, irq_out}, 32'h1);
      flag_empty[2] = 1'b0;
      step(); step();
      rd(BASE + 16'd5);
      check("R4 empty fall ignored", {24'b0, bus_rdata}, 32'h2);

      // unmapped addresses (R10)
      wr(16'hE658, 8'hFF);
      check("R10 unmapped reads zero", {24'b0, bus_rdata}, 32'h0);
      rd(16'hE64F);
      rd(BASE + 16'd6);
      check("R10 neighbour unchanged", {24'b0, bus_rdata}, 32'h1);

      for (int e = 0; e < 4; e++) wr(BASE + 16'(2*e+1), 8'h07);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         int pick;
         for (int e = 0; e < 4; e++) begin
            if ($urandom % 8 == 0) flag_prog[e]  = ~flag_prog[e];
            if ($urandom % 8 == 0) flag_empty[e] = ~flag_empty[e];
            if ($urandom % 8 == 0) flag_full[e]  = ~flag_full[e];
         end
         pick = int'($urandom % 12);
         if (pick < 8)        bus_addr = BASE + 16'(pick);
         else if (pick == 8)  bus_addr = SETUP;
         else if (pick == 9)  bus_addr = 16'hE658;
         else if (pick == 10) bus_addr = 16'hE64F;
         else                 bus_addr = 16'($urandom);
         bus_we    = ($urandom % 4 == 0);
         bus_wdata = 8'($urandom);
         step();
      end
      bus_we = 1'b0;

      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule